// File: doc/BRIEF.md
# Multiplexed Nibble/Byte Display RAM Host Port

This block is the host-facing parallel port of a display RAM. A host reaches the RAM through one shared bidirectional bus that is 4 bits wide (narrow mode) or 8 bits wide (wide mode). It also uses an active-low enable, a select that marks each transfer as address or data, and active-low read and write strobes. The host first loads an address over the same pins that carry data: three nibbles in narrow mode, two bytes in wide mode. It then moves data one unit per strobe, and the address steps forward after every data transfer, so bursts need no further address phases.

Strobes, enable, select and bus are synchronised into a fast system clock, and every transfer takes effect when its strobe returns high. On the inside, the block issues single-cycle requests to a synchronous RAM or to a small control register file. The address range that selects the register file depends on the bus width. The block drives its output-enable only while a data read is in progress.

Top module: `rp_host_port`

## Requirements
- R1: In narrow mode (wide_i=0), address transfers (sel_data_i=0) load the address as three nibbles from bus bits 3:0, in the order bits 11:8, then 7:4, then 3:0.
- R2: In wide mode (wide_i=1), the first address byte sets address bits 10:8 from bus bits 2:0 and clears bit 11, ignoring bus bits 7:3. The second byte sets bits 7:0.
- R3: A data write (sel_data_i=1) commits when wr_ni rises. It issues exactly one write request at the current address, carrying bus bits 3:0 with the upper bits zero in narrow mode or all 8 bits in wide mode. The address then advances by one.
- R4: While rd_ni is low in data mode, the block drives bus_o with the word stored at the current address (upper nibble zero in narrow mode), with bus_oe_o high. When rd_ni rises, the address advances by one and bus_oe_o returns low.
- R5: The address wraps from FFFh to 000h in narrow mode and from 7FFh to 000h in wide mode.
- R6: While en_ni is high, strobes cause no request, no bus drive and no address change.
- R7: The address phase counter restarts at the first phase when sel_data_i returns to 0 from 1 or when en_ni goes high.
- R8: Addresses A00h–A05h in narrow mode and 500h–502h in wide mode go to the register port, with reg_idx_o = address minus base (0..5 or 0..2). A06h in narrow mode and 503h in wide mode go to the RAM port.
- R9: With sel_data_i=0, a read strobe drives nothing and issues no request, and address writes issue no request.
- R10: With both strobes low, bus_oe_o stays low.
- R11: After reset the block issues no request, bus_oe_o is low and the address is 000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wide_i | input | 1 | Bus width: 0 narrow (4 bits), 1 wide (8 bits) |
| en_ni | input | 1 | Access enable, active low |
| sel_data_i | input | 1 | 0 address transfer, 1 data transfer |
| wr_ni | input | 1 | Write strobe, active low |
| rd_ni | input | 1 | Read strobe, active low |
| bus_i | input | 8 | Bus value driven by host |
| bus_o | output | 8 | Bus value driven by block |
| bus_oe_o | output | 1 | Block drives the bus when high |
| mem_req_o | output | 1 | RAM request, one cycle |
| reg_req_o | output | 1 | Register file request, one cycle |
| req_we_o | output | 1 | Request is a write |
| req_addr_o | output | 12 | Request address |
| reg_idx_o | output | 3 | Register index for register requests |
| req_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | RAM read data, one cycle after request |
| reg_rdata_i | input | 8 | Register read data, one cycle after request |

## Verification
The bench targets the wrap points FFFh and 7FFh, where a design that masks with the wrong width would reach 800h or 1000h. It targets the register window edges A05h/A06h and 500h/502h/503h, where an off-by-one decode would send a RAM write to a register or the reverse. It restarts the phase by reselecting address mode or by disabling mid-sequence; a counter that did not restart would load nibbles into the wrong field. Disabled strobes, address-mode reads and overlapping strobes are checked for stray requests, address steps and bus drive.

// File: rtl/rp_pkg.sv
package rp_pkg;
  localparam int ADDR_W        = 12;
  localparam int BUS_W         = 8;
  localparam int NIB_W         = 4;
  localparam int WIDE_AW       = 11;
  localparam int NARROW_PHASES = ADDR_W / NIB_W;
  localparam int WIDE_PHASES   = 2;
  localparam int WIDE_HI_W     = WIDE_AW - BUS_W;
  localparam int REG_IDX_W     = 3;
  localparam logic [ADDR_W-1:0] NARROW_REG_BASE = 12'hA00;
  localparam int                NARROW_REG_CNT  = 6;
  localparam logic [ADDR_W-1:0] WIDE_REG_BASE   = 12'h500;
  localparam int                WIDE_REG_CNT    = 3;
  localparam int PH_W = $clog2(NARROW_PHASES);

  typedef struct packed {
    logic                  we;
    logic                  is_reg;
    logic [ADDR_W-1:0]     addr;
    logic [REG_IDX_W-1:0]  idx;
    logic [BUS_W-1:0]      wdata;
  } xfer_t;
endpackage

// File: rtl/rp_sync.sv
module rp_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] qd_o
);
  logic [W-1:0] chain_q [STAGES+1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k <= STAGES; k++) chain_q[k] <= RST_VAL;
    end else begin
      chain_q[0] <= d_i;
      for (int k = 1; k <= STAGES; k++) chain_q[k] <= chain_q[k-1];
    end
  end

  assign q_o  = chain_q[STAGES-1];
  assign qd_o = chain_q[STAGES];
endmodule

// File: rtl/rp_addr_seq.sv
module rp_addr_seq
  import rp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wide_i,
  input  logic              restart_i,
  input  logic              load_i,
  input  logic              bump_i,
  input  logic [BUS_W-1:0]  din_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [PH_W-1:0]   phase_q;
  logic [ADDR_W-1:0] addr_q;
  logic [PH_W-1:0]   last_ph;
  logic [ADDR_W-1:0] wrap_mask;

  assign last_ph   = wide_i ? PH_W'(WIDE_PHASES - 1) : PH_W'(NARROW_PHASES - 1);
  assign wrap_mask = wide_i ? ADDR_W'((1 << WIDE_AW) - 1) : '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= '0;
    else if (restart_i) phase_q <= '0;
    else if (load_i) phase_q <= (phase_q == last_ph) ? '0 : phase_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
    end else if (load_i) begin
      if (!wide_i) begin
        addr_q[ADDR_W-1 - NIB_W*int'(phase_q) -: NIB_W] <= din_i[NIB_W-1:0];
      end else if (phase_q == '0) begin
        addr_q[ADDR_W-1:BUS_W] <= {{(ADDR_W-WIDE_AW){1'b0}}, din_i[WIDE_HI_W-1:0]};
      end else begin
        addr_q[BUS_W-1:0] <= din_i;
      end
    end else if (bump_i) begin
      addr_q <= (addr_q + 1'b1) & wrap_mask;
    end
  end

  assign addr_o = addr_q;

  AST_PHASE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(phase_q) < NARROW_PHASES); // R1
  AST_WIDE_TOP_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && wide_i && phase_q == '0 && !restart_i) |=> !addr_q[ADDR_W-1]); // R2
endmodule

// File: rtl/rp_access.sv
module rp_access
  import rp_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wide_i,
  input  logic                 en_on_i,
  input  logic                 wr_commit_i,
  input  logic                 rd_start_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [BUS_W-1:0]     wbus_i,
  input  logic [BUS_W-1:0]     mem_rdata_i,
  input  logic [BUS_W-1:0]     reg_rdata_i,
  output logic                 mem_req_o,
  output logic                 reg_req_o,
  output logic                 we_o,
  output logic [ADDR_W-1:0]    addr_o,
  output logic [REG_IDX_W-1:0] reg_idx_o,
  output logic [BUS_W-1:0]     wdata_o,
  output logic [BUS_W-1:0]     rdata_o
);
  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] offs;
  logic              reg_hit;
  xfer_t             nxt, cur_q;
  logic              req_q, pend_q, pend_reg_q;
  logic [BUS_W-1:0]  rdata_q, rsel;

  assign base    = wide_i ? WIDE_REG_BASE : NARROW_REG_BASE;
  assign offs    = addr_i - base;
  assign reg_hit = (addr_i >= base) &&
                   (offs < (wide_i ? ADDR_W'(WIDE_REG_CNT) : ADDR_W'(NARROW_REG_CNT)));

  always_comb begin
    nxt.we     = wr_commit_i;
    nxt.is_reg = reg_hit;
    nxt.addr   = addr_i;
    nxt.idx    = reg_hit ? offs[REG_IDX_W-1:0] : '0;
    nxt.wdata  = wide_i ? wbus_i : {{(BUS_W-NIB_W){1'b0}}, wbus_i[NIB_W-1:0]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0;
      cur_q <= '0;
    end else begin
      req_q <= en_on_i && (wr_commit_i || rd_start_i);
      if (wr_commit_i || rd_start_i) cur_q <= nxt;
    end
  end

  assign rsel = pend_reg_q ? reg_rdata_i : mem_rdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= 1'b0;
      pend_reg_q <= 1'b0;
      rdata_q    <= '0;
    end else begin
      pend_q     <= req_q && !cur_q.we;
      pend_reg_q <= cur_q.is_reg;
      if (pend_q)
        rdata_q <= wide_i ? rsel : {{(BUS_W-NIB_W){1'b0}}, rsel[NIB_W-1:0]};
    end
  end

  assign mem_req_o = req_q && !cur_q.is_reg;
  assign reg_req_o = req_q && cur_q.is_reg;
  assign we_o      = cur_q.we;
  assign addr_o    = cur_q.addr;
  assign reg_idx_o = cur_q.idx;
  assign wdata_o   = cur_q.wdata;
  assign rdata_o   = rdata_q;

  AST_QUIET_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_on_i |=> !(mem_req_o || reg_req_o)); // R6
  AST_REG_IDX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_o |-> int'(reg_idx_o) < NARROW_REG_CNT); // R8
  AST_NARROW_READ_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !wide_i) |=> rdata_o[BUS_W-1:NIB_W] == '0); // R4
endmodule

// File: rtl/rp_host_port.sv
module rp_host_port
  import rp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wide_i,
  input  logic        en_ni,
  input  logic        sel_data_i,
  input  logic        wr_ni,
  input  logic        rd_ni,
  input  logic [7:0]  bus_i,
  output logic [7:0]  bus_o,
  output logic        bus_oe_o,
  output logic        mem_req_o,
  output logic        reg_req_o,
  output logic        req_we_o,
  output logic [11:0] req_addr_o,
  output logic [2:0]  reg_idx_o,
  output logic [7:0]  req_wdata_o,
  input  logic [7:0]  mem_rdata_i,
  input  logic [7:0]  reg_rdata_i
);
  localparam int SW = BUS_W + 4;
  localparam logic [SW-1:0] SYNC_RST = {{BUS_W{1'b0}}, 4'b1011};

  logic [SW-1:0] s_now, s_dly;
  logic [BUS_W-1:0] bus_dly;
  logic en_on, sel_d, sel_dd, wr_s, wr_d, rd_s, rd_d;
  logic wr_rise, rd_fall, rd_rise, sel_back;
  logic load, wr_commit, rd_start, rd_done, restart, bump;
  logic [ADDR_W-1:0] cur_addr;

  rp_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk_i, .rst_ni,
    .d_i ({bus_i, en_ni, sel_data_i, wr_ni, rd_ni}),
    .q_o (s_now),
    .qd_o(s_dly)
  );

  assign en_on   = !s_now[3];
  assign sel_d   = s_now[2];
  assign sel_dd  = s_dly[2];
  assign wr_s    = s_now[1];
  assign wr_d    = s_dly[1];
  assign rd_s    = s_now[0];
  assign rd_d    = s_dly[0];
  assign bus_dly = s_dly[SW-1:4];

  assign wr_rise  = wr_s && !wr_d;
  assign rd_fall  = !rd_s && rd_d;
  assign rd_rise  = rd_s && !rd_d;
  assign sel_back = !sel_d && sel_dd;

  assign load      = en_on && wr_rise && !sel_d;
  assign wr_commit = en_on && wr_rise && sel_d;
  assign rd_start  = en_on && rd_fall && sel_d && wr_s;
  assign rd_done   = en_on && rd_rise && sel_d;
  assign restart   = !en_on || sel_back;
  assign bump      = wr_commit || rd_done;

  rp_addr_seq u_addr (
    .clk_i, .rst_ni, .wide_i,
    .restart_i(restart),
    .load_i   (load && !restart),
    .bump_i   (bump),
    .din_i    (bus_dly),
    .addr_o   (cur_addr)
  );

  rp_access u_acc (
    .clk_i, .rst_ni, .wide_i,
    .en_on_i    (en_on),
    .wr_commit_i(wr_commit),
    .rd_start_i (rd_start),
    .addr_i     (cur_addr),
    .wbus_i     (bus_dly),
    .mem_rdata_i,
    .reg_rdata_i,
    .mem_req_o,
    .reg_req_o,
    .we_o       (req_we_o),
    .addr_o     (req_addr_o),
    .reg_idx_o,
    .wdata_o    (req_wdata_o),
    .rdata_o    (bus_o)
  );

  assign bus_oe_o = en_on && sel_d && !rd_s && wr_s;

  AST_PORTS_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_req_o && reg_req_o)); // R8
  AST_NO_DRIVE_BOTH_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_s && !rd_s) |-> !bus_oe_o); // R10
  AST_NO_DRIVE_ADDR_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_d |-> !bus_oe_o); // R9
endmodule

// File: tb/tb_rp_host_port.sv
module tb_rp_host_port;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wide = 1'b0, en_n = 1'b1, sel = 1'b1, wr_n = 1'b1, rd_n = 1'b1;
  logic [7:0] bus_drv = '0;
  logic [7:0] bus_o, mem_rdata, reg_rdata;
  logic bus_oe, mem_req, reg_req, req_we;
  logic [11:0] req_addr;
  logic [2:0] reg_idx;
  logic [7:0] req_wdata;

  int checks = 0, fails = 0;
  int mem_cnt = 0, reg_cnt = 0;
  logic [11:0] last_addr;
  logic [7:0]  last_data;
  logic [2:0]  last_idx;
  logic [7:0]  mem [4096];
  logic [7:0]  regs [8];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rp_host_port dut (
    .clk_i(clk), .rst_ni(rst_n), .wide_i(wide), .en_ni(en_n), .sel_data_i(sel),
    .wr_ni(wr_n), .rd_ni(rd_n), .bus_i(bus_drv), .bus_o(bus_o), .bus_oe_o(bus_oe),
    .mem_req_o(mem_req), .reg_req_o(reg_req), .req_we_o(req_we), .req_addr_o(req_addr),
    .reg_idx_o(reg_idx), .req_wdata_o(req_wdata), .mem_rdata_i(mem_rdata),
    .reg_rdata_i(reg_rdata)
  );

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'(i) ^ 8'h5A;
    for (int i = 0; i < 8; i++) regs[i] = '0;
    mem_rdata = '0;
    reg_rdata = '0;
  end

  always @(posedge clk) begin
    if (mem_req) begin
      mem_cnt <= mem_cnt + 1;
      last_addr <= req_addr;
      if (req_we) begin mem[req_addr] <= req_wdata; last_data <= req_wdata; end
      else mem_rdata <= mem[req_addr];
    end
    if (reg_req) begin
      reg_cnt <= reg_cnt + 1;
      last_idx <= reg_idx;
      last_addr <= req_addr;
      if (req_we) begin regs[reg_idx] <= req_wdata; last_data <= req_wdata; end
      else reg_rdata <= regs[reg_idx];
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe_wr(input logic [7:0] v);
    bus_drv = v; cyc(1);
    wr_n = 1'b0; cyc(6);
    wr_n = 1'b1; cyc(5);
  endtask

  task automatic strobe_rd(output logic [7:0] v, output logic oe);
    rd_n = 1'b0; cyc(8);
    v = bus_o; oe = bus_oe;
    rd_n = 1'b1; cyc(5);
  endtask

  task automatic set_addr(input logic [11:0] a);
    sel = 1'b0; cyc(4);
    if (wide) begin
      strobe_wr({5'b0, a[10:8]});
      strobe_wr(a[7:0]);
    end else begin
      strobe_wr({4'b0, a[11:8]});
      strobe_wr({4'b0, a[7:4]});
      strobe_wr({4'b0, a[3:0]});
    end
    sel = 1'b1; cyc(4);
  endtask

  task automatic t_reset();
    chk("R11 oe", bus_oe, 0);
    chk("R11 mem_req", mem_req, 0);
    chk("R11 reg_req", reg_req, 0);
    en_n = 1'b0; cyc(4);
    strobe_wr(8'h0C);
    chk("R11 first write addr", last_addr, 12'h000);
  endtask

  task automatic t_narrow_addr();
    int c0;
    wide = 1'b0; cyc(2);
    c0 = mem_cnt + reg_cnt;
    set_addr(12'h3A5);
    chk("R9 no request from address writes", mem_cnt + reg_cnt, c0);
    strobe_wr(8'hF9);
    chk("R1 nibble address", last_addr, 12'h3A5);
    chk("R3 narrow data masked", last_data, 8'h09);
    chk("R3 one request", mem_cnt + reg_cnt, c0 + 1);
    strobe_wr(8'h06);
    chk("R3 address advanced", last_addr, 12'h3A6);
  endtask

  task automatic t_wide_addr();
    wide = 1'b1; cyc(2);
    set_addr(12'h000);
    sel = 1'b0; cyc(4);
    strobe_wr(8'hF2);
    strobe_wr(8'h34);
    sel = 1'b1; cyc(4);
    strobe_wr(8'hC7);
    chk("R2 byte address, upper bits ignored", last_addr, 12'h234);
    chk("R3 wide data", last_data, 8'hC7);
  endtask

  task automatic t_read();
    logic [7:0] v; logic oe;
    wide = 1'b1; cyc(2);
    set_addr(12'h234);
    strobe_rd(v, oe);
    chk("R4 read data", v, 8'hC7);
    chk("R4 oe during read", oe, 1);
    chk("R4 oe after read", bus_oe, 0);
    strobe_rd(v, oe);
    chk("R4 read after increment", v, 8'h35 ^ 8'h5A);
    wide = 1'b0; cyc(2);
    set_addr(12'h234);
    strobe_rd(v, oe);
    chk("R4 narrow read upper zero", v, 8'h07);
  endtask

  task automatic t_wrap();
    wide = 1'b0; cyc(2);
    set_addr(12'hFFF);
    strobe_wr(8'h01);
    chk("R5 narrow top", last_addr, 12'hFFF);
    strobe_wr(8'h02);
    chk("R5 narrow wrap", last_addr, 12'h000);
    wide = 1'b1; cyc(2);
    set_addr(12'h7FF);
    strobe_wr(8'h11);
    chk("R5 wide top", last_addr, 12'h7FF);
    strobe_wr(8'h22);
    chk("R5 wide wrap", last_addr, 12'h000);
  endtask

  task automatic t_disabled();
    int c0; logic [7:0] v; logic oe;
    wide = 1'b1; cyc(2);
    set_addr(12'h100);
    en_n = 1'b1; cyc(4);
    c0 = mem_cnt + reg_cnt;
    strobe_wr(8'h55);
    strobe_rd(v, oe);
    chk("R6 no drive while disabled", oe, 0);
    chk("R6 no request while disabled", mem_cnt + reg_cnt, c0);
    en_n = 1'b0; cyc(4);
    strobe_wr(8'hAA);
    chk("R6 address unchanged", last_addr, 12'h100);
  endtask

  task automatic t_restart();
    wide = 1'b0; cyc(2);
    sel = 1'b0; cyc(4);
    strobe_wr(8'h01);
    sel = 1'b1; cyc(4);
    set_addr(12'h456);
    strobe_wr(8'h03);
    chk("R7 restart on select", last_addr, 12'h456);
    sel = 1'b0; cyc(4);
    strobe_wr(8'h02);
    en_n = 1'b1; cyc(4);
    en_n = 1'b0; cyc(4);
    strobe_wr(8'h07);
    strobe_wr(8'h08);
    strobe_wr(8'h09);
    sel = 1'b1; cyc(4);
    strobe_wr(8'h04);
    chk("R7 restart on disable", last_addr, 12'h789);
  endtask

  task automatic t_regs();
    int m0, r0; logic [7:0] v; logic oe;
    wide = 1'b0; cyc(2);
    set_addr(12'hA05);
    m0 = mem_cnt; r0 = reg_cnt;
    strobe_wr(8'h03);
    chk("R8 narrow A05 to register", reg_cnt, r0 + 1);
    chk("R8 narrow index", last_idx, 5);
    chk("R8 narrow no RAM", mem_cnt, m0);
    strobe_wr(8'h04);
    chk("R8 narrow A06 to RAM", mem_cnt, m0 + 1);
    wide = 1'b1; cyc(2);
    set_addr(12'h502);
    r0 = reg_cnt; m0 = mem_cnt;
    strobe_wr(8'h99);
    chk("R8 wide 502 index", last_idx, 2);
    chk("R8 wide 502 to register", reg_cnt, r0 + 1);
    strobe_wr(8'h98);
    chk("R8 wide 503 to RAM", mem_cnt, m0 + 1);
    set_addr(12'h500);
    strobe_wr(8'h3C);
    set_addr(12'h500);
    strobe_rd(v, oe);
    chk("R8 register read back", v, 8'h3C);
  endtask

  task automatic t_addr_mode_read();
    int c0; logic [7:0] v; logic oe;
    sel = 1'b0; cyc(4);
    c0 = mem_cnt + reg_cnt;
    strobe_rd(v, oe);
    chk("R9 no drive in address mode", oe, 0);
    chk("R9 no request in address mode", mem_cnt + reg_cnt, c0);
    sel = 1'b1; cyc(4);
  endtask

  task automatic t_both_low();
    wr_n = 1'b0; rd_n = 1'b0; cyc(8);
    chk("R10 no drive with both strobes low", bus_oe, 0);
    rd_n = 1'b1; cyc(5);
    wr_n = 1'b1; cyc(5);
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    t_reset();
    t_narrow_addr();
    t_wide_addr();
    t_read();
    t_wrap();
    t_disabled();
    t_restart();
    t_regs();
    t_addr_mode_read();
    t_both_low();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule